// File: doc/BRIEF.md
# Multi-Endpoint Transmit FIFO Bank

This block holds the outgoing data of three transmit-only endpoints, each in its own FIFO. The depths differ: 8, 6 and 2 bytes by default. A CPU reaches all three FIFOs through a small register window. It first writes an endpoint number into a select register. Every later write to the shared data register or the shared transmit control register then goes to that endpoint only. Writing the control register with its enable bit set marks the endpoint ready. Once an endpoint is ready, its FIFO stays closed to the CPU until the serial side has drained it.

The serial engine takes bytes through a pop port. It names the endpoint with a 2-bit index and receives the oldest byte of that FIFO one cycle later. Per-endpoint ready flags, byte counts and sticky overflow flags are visible at all times. Packet encoding, handshakes and data toggles belong to other blocks.

Top module: `ep_tx_bank`

## Requirements
- R1: After reset, every byte count, ready flag and overflow flag is 0, `pop_data_o` and `pop_err_o` are 0, and no endpoint is selected.
- R2: A write with `cpu_addr_i`=1 (data) while the select register holds 1, 2 or 3 appends `cpu_wdata_i` to that endpoint's FIFO only. Its count rises by one after that clock edge, and the other counts do not change.
- R3: The FIFO depths are 8, 6 and 2 bytes for endpoints 1, 2 and 3. A data write to a full FIFO is dropped and sets that endpoint's overflow bit (`overflow_o` bit ep-1). The bit stays set until reset.
- R4: A write with `cpu_addr_i`=2 (control) sets the selected endpoint's ready bit (`ready_o` bit ep-1) to `cpu_wdata_i` bit 0.
- R5: A data write to an endpoint whose ready bit is set is dropped. It leaves the count unchanged and does not set the overflow bit.
- R6: A cycle with `pop_i`=1 and `pop_ep_i` equal to 1, 2 or 3, when that FIFO holds data, removes its oldest byte. The byte appears on `pop_data_o` after that edge and stays there until the next pop. Bytes leave in the order they were written, including across pointer wrap-around.
- R7: The pop that removes the last byte of a ready endpoint clears its ready bit.
- R8: A pop from an empty FIFO, or with `pop_ep_i`=0, drives `pop_data_o` to 0 and raises `pop_err_o` for exactly that following cycle. No count changes.
- R9: The select register is written with `cpu_addr_i`=0 and holds the whole byte. While it holds a value outside 1 to 3, data and control writes have no effect. Writes with `cpu_addr_i`=3 are always ignored.
- R10: A data write and a pop on the same not-ready, non-full endpoint in one cycle both take effect. The count is unchanged, and the order of bytes is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_we_i | input | 1 | CPU register write strobe |
| cpu_addr_i | input | 2 | Register: 0 select, 1 data, 2 control, 3 reserved |
| cpu_wdata_i | input | 8 | CPU write data |
| pop_i | input | 1 | Serial-side pop request |
| pop_ep_i | input | 2 | Endpoint to pop from (1 to 3) |
| pop_data_o | output | 8 | Byte taken by the last pop, 0 on error |
| pop_err_o | output | 1 | Last pop found no data |
| ready_o | output | 3 | Per-endpoint ready flags, bit 0 = endpoint 1 |
| count_o | output | 12 | Per-endpoint byte counts, 4 bits each, endpoint 1 in bits 3:0 |
| overflow_o | output | 3 | Sticky per-endpoint overflow flags |

## Verification
The bench builds the block with its default depths of 8, 6 and 2. Every full boundary is therefore reached with a handful of writes, and the overflow path can be checked on each endpoint. The 6-deep FIFO is not a power of two. Filling it, partly draining it and refilling it forces its pointers through the explicit wrap, and the order of the bytes that come out is checked. The 2-deep FIFO becomes full after two writes, so an overflow there appears right after the first fill.

// File: rtl/ep_tx_pkg.sv
package ep_tx_pkg;
  localparam int DW     = 8;
  localparam int NUM_EP = 3;
  localparam int EPW    = 2;
  localparam int AW     = 2;
  localparam int CTRL_EN_BIT = 0;

  typedef enum logic [AW-1:0] {
    REG_SEL  = 2'd0,
    REG_DATA = 2'd1,
    REG_CTRL = 2'd2,
    REG_RSVD = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/ep_fifo.sv
module ep_fifo #(
  parameter int DEPTH = 8,
  parameter int DW    = 8,
  parameter int CW    = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          pop_i,
  output logic [DW-1:0] head_o,
  output logic [CW-1:0] count_o,
  output logic          full_o,
  output logic          empty_o
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wr_ptr_q, rd_ptr_q;
  logic [CW-1:0] cnt_q;
  logic          push_ok, pop_ok;

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign push_ok = push_i & ~full_o;
  assign pop_ok  = pop_i & ~empty_o;
  assign head_o  = mem[rd_ptr_q];
  assign count_o = cnt_q;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == LAST) ? '0 : p + PW'(1);
  endfunction

  always_ff @(posedge clk_i) begin
    if (push_ok) mem[wr_ptr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (push_ok) wr_ptr_q <= bump(wr_ptr_q);
      if (pop_ok)  rd_ptr_q <= bump(rd_ptr_q);
      case ({push_ok, pop_ok})
        2'b10:   cnt_q <= cnt_q + CW'(1);
        2'b01:   cnt_q <= cnt_q - CW'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/ep_cpu_dec.sv
module ep_cpu_dec
  import ep_tx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [NUM_EP-1:0] push_o,
  output logic [NUM_EP-1:0] ctrl_we_o,
  output logic              ctrl_en_o,
  output logic              sel_valid_o
);
  logic [DW-1:0] sel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sel_q <= '0;
    else if (we_i && addr_i == REG_SEL) sel_q <= wdata_i;
  end

  assign sel_valid_o = (sel_q >= DW'(1)) && (sel_q <= DW'(NUM_EP));
  assign ctrl_en_o   = wdata_i[CTRL_EN_BIT];

  for (genvar i = 0; i < NUM_EP; i++) begin : g_hit
    logic hit;
    assign hit          = (sel_q == DW'(i + 1));
    assign push_o[i]    = hit & we_i & (addr_i == REG_DATA);
    assign ctrl_we_o[i] = hit & we_i & (addr_i == REG_CTRL);
  end
endmodule

// File: rtl/ep_pop_port.sv
module ep_pop_port
  import ep_tx_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 pop_i,
  input  logic [EPW-1:0]       pop_ep_i,
  input  logic [NUM_EP*DW-1:0] head_i,
  input  logic [NUM_EP-1:0]    empty_i,
  output logic [NUM_EP-1:0]    pop_hit_o,
  output logic [DW-1:0]        data_o,
  output logic                 err_o
);
  logic [DW-1:0] head_sel;

  always_comb begin
    head_sel = '0;
    for (int i = 0; i < NUM_EP; i++) begin
      pop_hit_o[i] = pop_i && (pop_ep_i == EPW'(i + 1)) && !empty_i[i];
      if (pop_hit_o[i]) head_sel = head_i[i*DW +: DW];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o <= '0;
      err_o  <= 1'b0;
    end else if (pop_i) begin
      data_o <= (|pop_hit_o) ? head_sel : '0;
      err_o  <= ~(|pop_hit_o);
    end else begin
      err_o  <= 1'b0;
    end
  end
endmodule

// File: rtl/ep_tx_bank.sv
module ep_tx_bank
  import ep_tx_pkg::*;
#(
  parameter int DEPTH1 = 8,
  parameter int DEPTH2 = 6,
  parameter int DEPTH3 = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpu_we_i,
  input  logic [AW-1:0]     cpu_addr_i,
  input  logic [DW-1:0]     cpu_wdata_i,
  input  logic              pop_i,
  input  logic [EPW-1:0]    pop_ep_i,
  output logic [DW-1:0]     pop_data_o,
  output logic              pop_err_o,
  output logic [NUM_EP-1:0] ready_o,
  output logic [NUM_EP*($clog2(((DEPTH1 > DEPTH2 ? DEPTH1 : DEPTH2) > DEPTH3 ?
                (DEPTH1 > DEPTH2 ? DEPTH1 : DEPTH2) : DEPTH3) + 1))-1:0] count_o,
  output logic [NUM_EP-1:0] overflow_o
);
  localparam int MAXD12 = (DEPTH1 > DEPTH2) ? DEPTH1 : DEPTH2;
  localparam int MAXD   = (MAXD12 > DEPTH3) ? MAXD12 : DEPTH3;
  localparam int CW     = $clog2(MAXD + 1);

  logic [NUM_EP-1:0]    push_req, ctrl_we, pop_hit, full, empty;
  logic                 ctrl_en, sel_valid;
  logic [NUM_EP*DW-1:0] heads;

  ep_cpu_dec u_dec (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (cpu_we_i),
    .addr_i     (cpu_addr_i),
    .wdata_i    (cpu_wdata_i),
    .push_o     (push_req),
    .ctrl_we_o  (ctrl_we),
    .ctrl_en_o  (ctrl_en),
    .sel_valid_o(sel_valid)
  );

  for (genvar i = 0; i < NUM_EP; i++) begin : g_ep
    localparam int D = (i == 0) ? DEPTH1 : (i == 1) ? DEPTH2 : DEPTH3;
    logic          ready_q, ovf_q, push_ok;
    logic [CW-1:0] cnt;

    // CPU is locked out of a ready endpoint; full drops the byte and flags it
    assign push_ok = push_req[i] & ~ready_q & ~full[i];

    ep_fifo #(.DEPTH(D), .DW(DW), .CW(CW)) u_fifo (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .push_i (push_ok),
      .wdata_i(cpu_wdata_i),
      .pop_i  (pop_hit[i]),
      .head_o (heads[i*DW +: DW]),
      .count_o(cnt),
      .full_o (full[i]),
      .empty_o(empty[i])
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ready_q <= 1'b0;
        ovf_q   <= 1'b0;
      end else begin
        if (push_req[i] && !ready_q && full[i]) ovf_q <= 1'b1;
        if (ctrl_we[i])                              ready_q <= ctrl_en;
        else if (pop_hit[i] && cnt == CW'(1))        ready_q <= 1'b0;
      end
    end

    assign ready_o[i]           = ready_q;
    assign overflow_o[i]        = ovf_q;
    assign count_o[i*CW +: CW]  = cnt;
  end

  ep_pop_port u_pop (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .pop_i    (pop_i),
    .pop_ep_i (pop_ep_i),
    .head_i   (heads),
    .empty_i  (empty),
    .pop_hit_o(pop_hit),
    .data_o   (pop_data_o),
    .err_o    (pop_err_o)
  );
endmodule

// File: rtl/ep_tx_bank_chk.sv
module ep_tx_bank_chk
  import ep_tx_pkg::*;
#(
  parameter int DEPTH1 = 8,
  parameter int DEPTH2 = 6,
  parameter int DEPTH3 = 2,
  parameter int CW     = 4
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 cpu_we_i,
  input logic [AW-1:0]        cpu_addr_i,
  input logic                 pop_i,
  input logic [EPW-1:0]       pop_ep_i,
  input logic [DW-1:0]        pop_data_o,
  input logic                 pop_err_o,
  input logic [NUM_EP-1:0]    ready_o,
  input logic [NUM_EP*CW-1:0] count_o,
  input logic [NUM_EP-1:0]    overflow_o,
  input logic                 sel_valid
);
  a_r8_err_zero_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_err_o |-> pop_data_o == '0);

  for (genvar i = 0; i < NUM_EP; i++) begin : g_chk
    localparam int D = (i == 0) ? DEPTH1 : (i == 1) ? DEPTH2 : DEPTH3;
    logic ctrl_wr;
    assign ctrl_wr = cpu_we_i && (cpu_addr_i == REG_CTRL);

    a_r3_count_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
      count_o[i*CW +: CW] <= CW'(D));

    a_r3_ovf_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
      overflow_o[i] |=> overflow_o[i]);

    a_r5_no_grow_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ready_o[i] |=> count_o[i*CW +: CW] <= $past(count_o[i*CW +: CW]));

    a_r7_ready_drain: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ready_o[i] && count_o[i*CW +: CW] == CW'(1) && pop_i &&
       pop_ep_i == EPW'(i + 1) && !ctrl_wr) |=> !ready_o[i]);

    a_r9_no_effect: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!sel_valid && !pop_i) |=>
        ($stable(count_o[i*CW +: CW]) && $stable(ready_o[i]) && $stable(overflow_o[i])));
  end
endmodule

bind ep_tx_bank ep_tx_bank_chk #(
  .DEPTH1(DEPTH1), .DEPTH2(DEPTH2), .DEPTH3(DEPTH3), .CW(CW)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .cpu_we_i  (cpu_we_i),
  .cpu_addr_i(cpu_addr_i),
  .pop_i     (pop_i),
  .pop_ep_i  (pop_ep_i),
  .pop_data_o(pop_data_o),
  .pop_err_o (pop_err_o),
  .ready_o   (ready_o),
  .count_o   (count_o),
  .overflow_o(overflow_o),
  .sel_valid (sel_valid)
);

// File: tb/ep_tx_bank_bench.sv
module ep_tx_bank_bench;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 4;
  localparam int WD_CYCLES = 20000;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          cpu_we = 1'b0;
  logic [1:0]    cpu_addr = '0;
  logic [7:0]    cpu_wdata = '0;
  logic          pop = 1'b0;
  logic [1:0]    pop_ep = '0;
  logic [7:0]    pop_data;
  logic          pop_err;
  logic [2:0]    ready;
  logic [3*CW-1:0] count;
  logic [2:0]    ovf;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ep_tx_bank u_ep_tx_bank (
    .clk_i(clk), .rst_ni(rst_ni),
    .cpu_we_i(cpu_we), .cpu_addr_i(cpu_addr), .cpu_wdata_i(cpu_wdata),
    .pop_i(pop), .pop_ep_i(pop_ep),
    .pop_data_o(pop_data), .pop_err_o(pop_err),
    .ready_o(ready), .count_o(count), .overflow_o(ovf)
  );

  function automatic int cnt(input int ep);
    return int'(count[(ep-1)*CW +: CW]);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0; cpu_we = 1'b0; pop = 1'b0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
  endtask

  task automatic cpu_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_we = 1'b1; cpu_addr = a; cpu_wdata = d;
    @(negedge clk);
    cpu_we = 1'b0;
  endtask

  task automatic do_pop(input logic [1:0] ep);
    @(negedge clk);
    pop = 1'b1; pop_ep = ep;
    @(negedge clk);
    pop = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    @(negedge clk);
    chk("R1 counts", int'(count), 0);
    chk("R1 ready", int'(ready), 0);
    chk("R1 overflow", int'(ovf), 0);
    chk("R1 pop_err", int'(pop_err), 0);
    chk("R1 pop_data", int'(pop_data), 0);
  endtask

  task automatic t_bad_select();
    do_reset();
    cpu_wr(2'd1, 8'h11);
    cpu_wr(2'd2, 8'h01);
    chk("R9 no select data", int'(count), 0);
    chk("R9 no select ctrl", int'(ready), 0);
    cpu_wr(2'd0, 8'h05);
    cpu_wr(2'd1, 8'h22);
    cpu_wr(2'd2, 8'h01);
    chk("R9 sel 5 data", int'(count), 0);
    chk("R9 sel 5 ctrl", int'(ready), 0);
    cpu_wr(2'd0, 8'h01);
    cpu_wr(2'd3, 8'h01);
    chk("R9 reserved addr", int'(count), 0);
    chk("R9 reserved ready", int'(ready), 0);
  endtask

  task automatic t_route();
    do_reset();
    cpu_wr(2'd0, 8'd2);
    for (int k = 0; k < 3; k++) cpu_wr(2'd1, 8'(8'h30 + k));
    chk("R2 ep2 count", cnt(2), 3);
    chk("R2 ep1 untouched", cnt(1), 0);
    chk("R2 ep3 untouched", cnt(3), 0);
    cpu_wr(2'd0, 8'd3);
    cpu_wr(2'd1, 8'h44);
    chk("R2 ep3 count", cnt(3), 1);
    chk("R2 ep2 unchanged", cnt(2), 3);
  endtask

  task automatic t_overflow();
    do_reset();
    cpu_wr(2'd0, 8'd3);
    cpu_wr(2'd1, 8'hA0); cpu_wr(2'd1, 8'hA1);
    chk("R3 ep3 full", cnt(3), 2);
    chk("R3 ep3 no ovf yet", int'(ovf), 0);
    cpu_wr(2'd1, 8'hA2);
    chk("R3 ep3 count held", cnt(3), 2);
    chk("R3 ep3 ovf", int'(ovf), 3'b100);
    cpu_wr(2'd0, 8'd1);
    for (int k = 0; k < 8; k++) cpu_wr(2'd1, 8'(k));
    chk("R3 ep1 depth 8", cnt(1), 8);
    chk("R3 ep1 no ovf at 8", int'(ovf[0]), 0);
    cpu_wr(2'd1, 8'hFF);
    chk("R3 ep1 ovf", int'(ovf[0]), 1);
    cpu_wr(2'd0, 8'd2);
    for (int k = 0; k < 7; k++) cpu_wr(2'd1, 8'(k));
    chk("R3 ep2 depth 6", cnt(2), 6);
    chk("R3 ep2 ovf", int'(ovf[1]), 1);
    do_pop(2'd3);
    chk("R3 ep3 first kept byte", int'(pop_data), 8'hA0);
    do_pop(2'd3);
    chk("R3 ep3 second kept byte", int'(pop_data), 8'hA1);
    chk("R3 ovf sticky", int'(ovf), 3'b111);
  endtask

  task automatic t_ready_lock();
    do_reset();
    cpu_wr(2'd0, 8'd2);
    cpu_wr(2'd1, 8'h55);
    cpu_wr(2'd2, 8'h01);
    chk("R4 ready set", int'(ready), 3'b010);
    cpu_wr(2'd1, 8'h66);
    chk("R5 locked count", cnt(2), 1);
    chk("R5 no ovf", int'(ovf), 0);
    cpu_wr(2'd2, 8'h00);
    chk("R4 ready cleared", int'(ready), 0);
    cpu_wr(2'd1, 8'h77);
    chk("R5 unlocked count", cnt(2), 2);
  endtask

  task automatic t_pop_order();
    do_reset();
    cpu_wr(2'd0, 8'd1);
    for (int k = 0; k < 5; k++) cpu_wr(2'd1, 8'(8'hC0 + k));
    cpu_wr(2'd2, 8'h01);
    for (int k = 0; k < 5; k++) begin
      do_pop(2'd1);
      chk("R6 order", int'(pop_data), 8'hC0 + k);
      chk("R6 count", cnt(1), 4 - k);
      if (k == 3) chk("R7 ready held before last", int'(ready[0]), 1);
    end
    chk("R7 ready cleared on drain", int'(ready[0]), 0);
  endtask

  task automatic t_wrap();
    do_reset();
    cpu_wr(2'd0, 8'd2);
    for (int k = 0; k < 6; k++) cpu_wr(2'd1, 8'(8'h10 + k));
    for (int k = 0; k < 4; k++) do_pop(2'd2);
    chk("R6 partial drain", int'(pop_data), 8'h13);
    for (int k = 0; k < 4; k++) cpu_wr(2'd1, 8'(8'h20 + k));
    chk("R6 refill count", cnt(2), 6);
    for (int k = 0; k < 6; k++) begin
      do_pop(2'd2);
      chk("R6 wrap order", int'(pop_data), (k < 2) ? (8'h14 + k) : (8'h20 + k - 2));
    end
  endtask

  task automatic t_underflow();
    do_reset();
    cpu_wr(2'd0, 8'd1);
    cpu_wr(2'd1, 8'h9A);
    do_pop(2'd1);
    chk("R6 good pop", int'(pop_data), 8'h9A);
    chk("R8 no err on good pop", int'(pop_err), 0);
    do_pop(2'd3);
    chk("R8 empty data", int'(pop_data), 0);
    chk("R8 empty err", int'(pop_err), 1);
    @(negedge clk);
    chk("R8 err one cycle", int'(pop_err), 0);
    cpu_wr(2'd1, 8'h5B);
    do_pop(2'd0);
    chk("R8 index 0 err", int'(pop_err), 1);
    chk("R8 index 0 keeps count", cnt(1), 1);
  endtask

  task automatic t_simul();
    do_reset();
    cpu_wr(2'd0, 8'd1);
    cpu_wr(2'd1, 8'hE0); cpu_wr(2'd1, 8'hE1);
    @(negedge clk);
    cpu_we = 1'b1; cpu_addr = 2'd1; cpu_wdata = 8'hE2;
    pop = 1'b1; pop_ep = 2'd1;
    @(negedge clk);
    cpu_we = 1'b0; pop = 1'b0;
    chk("R10 count unchanged", cnt(1), 2);
    chk("R10 popped head", int'(pop_data), 8'hE0);
    do_pop(2'd1);
    chk("R10 second", int'(pop_data), 8'hE1);
    do_pop(2'd1);
    chk("R10 third", int'(pop_data), 8'hE2);
  endtask

  initial begin
    t_reset();
    t_bad_select();
    t_route();
    t_overflow();
    t_ready_lock();
    t_pop_order();
    t_wrap();
    t_underflow();
    t_simul();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d cycles", WD_CYCLES, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule